// File: doc/BRIEF.md
# Dual-Port CAN Repeater Routing Core

This block is the digital routing core of a repeater that joins two CAN bus segments and one local protocol controller into a single logical bus. All lines use low for dominant and high for recessive. A dominant level from the local transmit line, or from an expansion transmit line used to chain several repeaters, is driven onto every enabled port. A dominant level heard on one enabled port is driven onto the other port and reported on the local and expansion receive lines.

Each port can be switched off through an active-low enable. A disabled port is never driven, and its received level is ignored. Received levels pass through a two-flop synchroniser. A lockout state machine then remembers which port started the current dominant period, so the level this unit drives back onto the other port is not heard again and held. The machine has five states. ST_IDLE means nothing is active. ST_LOCAL means a transmit input is dominant. ST_SRC0 and ST_SRC1 mean port 0 or port 1 started the dominant period. ST_SETTLE waits for the echo to die away.

The transitions are as follows. ST_IDLE goes to ST_LOCAL on a transmit request. Otherwise it goes to ST_SRC0 on port 0 dominant, or else to ST_SRC1 on port 1 dominant. ST_LOCAL goes to ST_SETTLE when both transmit inputs are recessive. ST_SRC0 and ST_SRC1 go to ST_SETTLE when their port is recessive. ST_SETTLE goes to ST_LOCAL on a transmit request, or to ST_IDLE once both ports read recessive. Each port also has a dominant timeout that forces its driver recessive and raises a fault flag.

Top module: `can_rpt_core`

## Requirements
- R1: After reset, and while every input is high (the pull-up default), both port drives, both receive outputs are high and both fault flags are low.
- R2: A low on `loc_tx_n` or `exp_tx_n` drives every enabled port low (bit i of `port_drv_n` for port i) one clock later.
- R3: While bit i of `port_en_n` is high, `port_drv_n[i]` stays high one clock later, and a low on `port_rx_n[i]` changes no output.
- R4: A low on `port_rx_n[i]` of an enabled port, with both transmit inputs high and the unit idle, drives the other port low and makes `loc_rx_n` and `exp_rx_n` low three clocks later.
- R5: A low `loc_tx_n` makes both `loc_rx_n` and `exp_rx_n` low one clock later whatever the enables. A low `exp_tx_n` makes only `loc_rx_n` low, and does not make `exp_rx_n` low.
- R6: `loc_rx_n` is high only when both transmit inputs are high and no port accepted by the lockout reports dominant.
- R7: The port that started a dominant period is not driven by it, and the received level of the driven port is ignored. After a single external dominant pulse the state machine returns to ST_IDLE, and all outputs are high once both ports read recessive.
- R8: If the drive request of a port stays dominant for DOM_LIMIT clocks, that port's drive goes high and its bit of `port_fault` goes high in the same clock.
- R9: A fault flag clears one clock after the port's drive request returns to recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_tx_n | input | 1 | Local transmit line, low = dominant |
| exp_tx_n | input | 1 | Expansion transmit line, low = dominant |
| port_en_n | input | 2 | Per-port enable, low = enabled |
| port_rx_n | input | 2 | Per-port received level, low = dominant |
| port_drv_n | output | 2 | Per-port drive request, low = dominant |
| loc_rx_n | output | 1 | Local receive line, low = dominant |
| exp_rx_n | output | 1 | Expansion receive line, low = dominant |
| port_fault | output | 2 | Per-port dominant timeout flag, high = fault |

## Verification
The latency of each result is fixed. A transmit input reaches the port drives and the receive outputs at the first rising edge after it changes. A port's received level reaches the outputs at the third edge: two synchroniser flops and then the output register. A timeout appears DOM_LIMIT edges after the request starts, and a fault flag clears at the first edge after the request ends. The bench sets inputs just after a rising edge and reads outputs at the falling edge after the edge count given above. A behavioural model, updated on each falling edge from the same input values, is compared with the outputs on every clock.

// File: rtl/can_rpt_pkg.sv
`timescale 1ns/1ps
package can_rpt_pkg;
    localparam int NPORT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_SRC0,
        ST_SRC1,
        ST_SETTLE
    } route_st_t;
endpackage

// File: rtl/can_rpt_sync.sv
`timescale 1ns/1ps
module can_rpt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '1;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/can_rpt_lockout.sv
`timescale 1ns/1ps
module can_rpt_lockout
    import can_rpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_dom,
    input  logic [NPORT-1:0] rx_dom,
    output logic [NPORT-1:0] fwd,
    output logic             heard
);
    route_st_t st_q, st_d;
    logic src0, src1;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (tx_dom)         st_d = ST_LOCAL;
                else if (rx_dom[0]) st_d = ST_SRC0;
                else if (rx_dom[1]) st_d = ST_SRC1;
            end
            ST_LOCAL:  if (!tx_dom)    st_d = ST_SETTLE;
            ST_SRC0:   if (!rx_dom[0]) st_d = ST_SETTLE;
            ST_SRC1:   if (!rx_dom[1]) st_d = ST_SETTLE;
            ST_SETTLE: begin
                if (tx_dom)              st_d = ST_LOCAL;
                else if (rx_dom == '0)   st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs: which port is accepted as the source this cycle
    always_comb begin
        src0  = (st_q == ST_SRC0) ||
                (st_q == ST_IDLE && !tx_dom && rx_dom[0]);
        src1  = (st_q == ST_SRC1) ||
                (st_q == ST_IDLE && !tx_dom && !rx_dom[0] && rx_dom[1]);
        fwd[1] = src0 && rx_dom[0];
        fwd[0] = src1 && rx_dom[1];
        heard  = fwd[0] || fwd[1];
    end

    // R7
    settle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETTLE && !tx_dom && rx_dom == '0) |=> st_q == ST_IDLE);
    // R7
    src_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SRC0) |=> st_q != ST_SRC1);
    // R7
    local_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCAL && !tx_dom) |=> st_q == ST_SETTLE);
endmodule

// File: rtl/can_rpt_guard.sv
`timescale 1ns/1ps
module can_rpt_guard #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic drv_n,
    output logic fault
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          hit;

    assign hit = req && (cnt >= CW'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            drv_n <= 1'b1;
            fault <= 1'b0;
        end else begin
            if (!req)     cnt <= '0;
            else if (!hit) cnt <= cnt + CW'(1);
            drv_n <= !(req && !hit);
            fault <= hit;
        end
    end

    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> drv_n);
    // R8
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT));
    // R9
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !fault);
    // R8
    limit_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cnt == CW'(LIMIT)) |=> (fault && drv_n));
endmodule

// File: rtl/can_rpt_core.sv
`timescale 1ns/1ps
module can_rpt_core
    import can_rpt_pkg::*;
#(
    parameter int DOM_LIMIT   = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loc_tx_n,
    input  logic             exp_tx_n,
    input  logic [NPORT-1:0] port_en_n,
    input  logic [NPORT-1:0] port_rx_n,
    output logic [NPORT-1:0] port_drv_n,
    output logic             loc_rx_n,
    output logic             exp_rx_n,
    output logic [NPORT-1:0] port_fault
);
    logic [NPORT-1:0] ena, rx_s, rx_dom, fwd, req;
    logic             tx_dom, heard;

    assign ena    = ~port_en_n;
    assign tx_dom = !loc_tx_n || !exp_tx_n;

    can_rpt_sync #(.W(NPORT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (port_rx_n),
        .q    (rx_s)
    );

    assign rx_dom = ena & ~rx_s;

    can_rpt_lockout u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .tx_dom(tx_dom),
        .rx_dom(rx_dom),
        .fwd   (fwd),
        .heard (heard)
    );

    assign req = ena & ({NPORT{tx_dom}} | fwd);

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        can_rpt_guard #(.LIMIT(DOM_LIMIT)) u_guard (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req[i]),
            .drv_n(port_drv_n[i]),
            .fault(port_fault[i])
        );

        // R3
        dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_en_n[i] |=> port_drv_n[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_rx_n <= 1'b1;
            exp_rx_n <= 1'b1;
        end else begin
            loc_rx_n <= !(tx_dom || heard);
            exp_rx_n <= loc_tx_n && !heard;
        end
    end

    // R5
    loc_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_tx_n |=> (!loc_rx_n && !exp_rx_n));
    // R5
    exp_to_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exp_tx_n |=> !loc_rx_n);
    // R6
    quiet_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_tx_n && exp_tx_n && !heard) |=> (loc_rx_n && exp_rx_n));
endmodule

// File: tb/can_rpt_core_tb.sv
`timescale 1ns/1ps
module can_rpt_core_tb;
    localparam int LIM = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_tx_n = 1'b1, exp_tx_n = 1'b1;
    logic [1:0] port_en_n = 2'b11;
    logic [1:0] ext_n = 2'b11;
    logic [1:0] port_rx_n, port_drv_n, port_fault;
    logic       loc_rx_n, exp_rx_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // wired-AND bus: our own drive and any outside node
    assign port_rx_n = port_drv_n & ext_n;

    can_rpt_core #(.DOM_LIMIT(LIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .loc_tx_n(loc_tx_n), .exp_tx_n(exp_tx_n),
        .port_en_n(port_en_n), .port_rx_n(port_rx_n), .port_drv_n(port_drv_n),
        .loc_rx_n(loc_rx_n), .exp_rx_n(exp_rx_n), .port_fault(port_fault)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_s1[2], m_s2[2];
    int m_mode;             // 0 idle,1 local,2 from p0,3 from p1,4 settling
    int m_cnt[2];
    bit e_drv[2], e_flt[2];
    bit e_lrx, e_erx;

    always @(negedge clk) begin
        if (!rst_n) begin
            foreach (m_s1[i]) begin
                m_s1[i] = 1; m_s2[i] = 1; m_cnt[i] = 0;
                e_drv[i] = 1; e_flt[i] = 0;
            end
            m_mode = 0; e_lrx = 1; e_erx = 1;
        end else begin
            bit txd, hear;
            bit rd[2], en[2], fw[2], rq[2];
            int nmode;
            for (int i = 0; i < 2; i++) begin
                chk("R2 port drive vs model", int'(port_drv_n[i]), int'(e_drv[i]));
                chk("R8 fault vs model", int'(port_fault[i]), int'(e_flt[i]));
            end
            chk("R6 local rx vs model", int'(loc_rx_n), int'(e_lrx));
            chk("R5 expansion rx vs model", int'(exp_rx_n), int'(e_erx));

            txd = (loc_tx_n == 0) || (exp_tx_n == 0);
            for (int i = 0; i < 2; i++) begin
                en[i] = (port_en_n[i] == 0);
                rd[i] = en[i] && (m_s2[i] == 0);
                fw[i] = 0;
            end
            if (m_mode == 2 || (m_mode == 0 && !txd && rd[0])) fw[1] = rd[0];
            else if (m_mode == 3 || (m_mode == 0 && !txd && rd[1])) fw[0] = rd[1];
            hear = fw[0] || fw[1];

            nmode = m_mode;
            case (m_mode)
                0: nmode = txd ? 1 : rd[0] ? 2 : rd[1] ? 3 : 0;
                1: if (!txd) nmode = 4;
                2: if (!rd[0]) nmode = 4;
                3: if (!rd[1]) nmode = 4;
                default: nmode = txd ? 1 : (!rd[0] && !rd[1]) ? 0 : 4;
            endcase
            m_mode = nmode;

            for (int i = 0; i < 2; i++) begin
                rq[i] = en[i] && (txd || fw[i]);
                if (rq[i] && m_cnt[i] >= LIM) begin
                    e_drv[i] = 1; e_flt[i] = 1;
                end else begin
                    e_drv[i] = !rq[i]; e_flt[i] = 0;
                    m_cnt[i] = rq[i] ? m_cnt[i] + 1 : 0;
                end
                m_s2[i] = m_s1[i];
                m_s1[i] = port_rx_n[i];
            end
            e_lrx = !(txd || hear);
            e_erx = (loc_tx_n == 1) && !hear;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] en, input logic ltx, input logic etx,
                         input logic [1:0] ext);
        @(posedge clk);
        #1;
        port_en_n = en; loc_tx_n = ltx; exp_tx_n = etx; ext_n = ext;
    endtask

    task automatic expect_out(input string tag, input logic [1:0] drv,
                              input logic lrx, input logic erx);
        chk({tag, " port_drv_n"}, int'(port_drv_n), int'(drv));
        chk({tag, " loc_rx_n"}, int'(loc_rx_n), int'(lrx));
        chk({tag, " exp_rx_n"}, int'(exp_rx_n), int'(erx));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        edges(3);
        // R1 reset and pull-up idle state
        expect_out("R1 idle", 2'b11, 1'b1, 1'b1);
        chk("R1 fault idle", int'(port_fault), 0);

        // R2 R3 R5 R6: every enable / transmit combination
        for (int en = 0; en < 4; en++) begin
            for (int tx = 0; tx < 4; tx++) begin
                logic ltx, etx, txd;
                logic [1:0] exp_drv;
                ltx = tx[1]; etx = tx[0];
                txd = !ltx || !etx;
                exp_drv = txd ? 2'(en) : 2'b11;
                drive(2'(en), ltx, etx, 2'b11);
                edges(1);
                expect_out("R2 R3 R5 R6 table", exp_drv, !txd, ltx);
                drive(2'(en), 1'b1, 1'b1, 2'b11);
                edges(6);
                expect_out("R7 table recover", 2'b11, 1'b1, 1'b1);
            end
        end

        // R4 R3: outside dominant on each port under each enable pattern
        for (int en = 0; en < 4; en++) begin
            for (int p = 0; p < 2; p++) begin
                logic [1:0] ext, exp_drv;
                logic on;
                ext = 2'b11; ext[p] = 1'b0;
                on = (en[p] == 0);
                exp_drv = 2'b11;
                if (on) exp_drv[1-p] = en[1-p];
                drive(2'(en), 1'b1, 1'b1, ext);
                edges(3);
                expect_out(on ? "R4 port heard" : "R3 port ignored", exp_drv, !on, !on);
                drive(2'(en), 1'b1, 1'b1, 2'b11);
                edges(8);
                expect_out("R7 no latch", 2'b11, 1'b1, 1'b1);
            end
        end

        // R7 single short pulse on port 1 with both ports enabled
        drive(2'b00, 1'b1, 1'b1, 2'b01);
        edges(3);
        chk("R7 source port not driven", int'(port_drv_n[1]), 1);
        chk("R7 other port driven", int'(port_drv_n[0]), 0);
        drive(2'b00, 1'b1, 1'b1, 2'b11);
        edges(10);
        expect_out("R7 pulse released", 2'b11, 1'b1, 1'b1);

        // R7 echo of own transmission is not heard back
        drive(2'b00, 1'b0, 1'b1, 2'b11);
        edges(4);
        drive(2'b00, 1'b1, 1'b1, 2'b11);
        edges(1);
        expect_out("R7 echo ignored", 2'b11, 1'b1, 1'b1);
        edges(6);

        // R8 R9 dominant timeout on a held transmit request
        drive(2'b00, 1'b0, 1'b1, 2'b11);
        edges(20);
        chk("R8 before limit drive", int'(port_drv_n), 0);
        chk("R8 before limit fault", int'(port_fault), 0);
        edges(25);
        chk("R8 after limit drive", int'(port_drv_n), 3);
        chk("R8 after limit fault", int'(port_fault), 3);
        chk("R8 local rx stays dominant", int'(loc_rx_n), 0);
        drive(2'b00, 1'b1, 1'b1, 2'b11);
        edges(1);
        chk("R9 fault cleared", int'(port_fault), 0);
        edges(6);
        expect_out("R9 idle after fault", 2'b11, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule